// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

This block watches the write and read ports of an eight-queue FIFO and reports, for every queue, whether at least one whole packet is waiting. Packets are delimited in-band: the two top bits of each 36-bit word flag a word as the first or the last word of a packet. A small open-packet state per queue filters the write-side markers. A saturating counter per queue counts the closed packets that have not yet begun to leave. Each time a word with the start flag leaves a queue on the read side, that queue's counter goes down by one.

Two active-low results are registered. A status bus carries one bit per queue. A single flag carries the status of the queue that the read port currently selects. Packet operation is chosen by an input that is latched while the synchronous reset is held. With packet operation off, both results stay inactive and the markers are ignored. The block stores no data and does not gate reads.

Top module: `pkt_ready_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `pkt_rdy_n` and every bit of `pkt_rdy_bus_n` are 1, and every queue count is zero.
- R2: `pkt_mode_sel` is captured only on rising clock edges with `rst_n` low. Changing it while `rst_n` is high has no effect.
- R3: Bit 34 of a word is the start flag and bit 35 is the end flag. A write (`wr_en`=1) of an end-flagged word to queue `wr_q` while that queue has an open start adds one to the queue's count and closes the open start.
- R4: A start-flagged write to a queue that already has an open start is ignored. An end-flagged write to a queue with no open start is ignored and leaves its count unchanged.
- R5: A written word carrying both flags is handled as an end flag alone.
- R6: A read (`rd_en`=1) of a word whose bit 34 is set subtracts one from the count of queue `rd_q`. Reads of other words change no count.
- R7: When an add and a subtract hit the same queue on the same edge, its count is unchanged.
- R8: A count saturates at zero and at QDEPTH/4, the most four-word packets a queue can hold.
- R9: One cycle after an edge, bit q of `pkt_rdy_bus_n` is 0 exactly when queue q's count after that edge is nonzero. This holds for every queue, whatever the read selection.
- R10: One cycle after an edge, `pkt_rdy_n` equals the bus bit of the queue that `rd_q` selected at that edge.
- R11: With packet operation latched off, all outputs stay 1 and no flag changes any count.
- R12: Traffic to one queue never changes the status of another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_mode_sel | input | 1 | Packet operation select, latched during reset |
| wr_en | input | 1 | A word is written on this edge |
| wr_q | input | 3 | Queue written |
| wr_word | input | 36 | Word written; bit 34 start flag, bit 35 end flag |
| rd_en | input | 1 | A word is read on this edge |
| rd_q | input | 3 | Queue selected for reading |
| rd_word | input | 36 | Word leaving the FIFO; bit 34 start flag |
| pkt_rdy_n | output | 1 | Low when the read-selected queue holds a whole packet |
| pkt_rdy_bus_n | output | 8 | Per-queue ready, low when queue holds a whole packet |

## Verification
Every result is due exactly one rising edge after the stimulus that caused it. The edge that applies an add or a subtract also loads the new status into the bus and flag registers. The bench therefore drives inputs on the falling edge and lets one rising edge pass. It then compares the outputs on the next falling edge against a count model updated for that same edge, before it drives anything new. The reset state is checked on the falling edge after a rising edge taken with reset held.

// File: rtl/pkt_rdy_pkg.sv
// Package: shared constants and marker type for the packet ready tracker.
// Assumes 36-bit words with the packet flags in the two top bits.
package pkt_rdy_pkg;
    localparam int WORD_W        = 36;
    localparam int START_BIT     = 34;
    localparam int END_BIT       = 35;
    localparam int MIN_PKT_WORDS = 4;

    typedef struct packed {
        logic first;   // word opens a packet
        logic last;    // word closes a packet
    } pkt_flags_t;

    // Pull the two in-band flags out of a word.
    function automatic pkt_flags_t take_flags(input logic [WORD_W-1:0] w);
        pkt_flags_t f;
        f.first = w[START_BIT];
        f.last  = w[END_BIT];
        return f;
    endfunction
endpackage

// File: rtl/pkt_wr_filter.sv
// Write-side marker filter. Keeps one open-start bit per queue and emits a
// one-cycle close pulse for a queue when an end flag follows a start flag.
// Assumes: repeated starts and orphan ends are dropped; a word with both
// flags counts as an end only. Single clock, synchronous active-low reset.
module pkt_wr_filter
    import pkt_rdy_pkg::*;
#(
    parameter int NUM_Q  = 8,
    parameter int QSEL_W = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [QSEL_W-1:0] wr_q,
    input  pkt_flags_t        flags,
    output logic [NUM_Q-1:0]  close_o
);
    logic [NUM_Q-1:0] open_q;
    logic [NUM_Q-1:0] hit;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
        // Decode whether this queue is written on this edge.
        always_comb hit[g] = enable && wr_en && (wr_q == QSEL_W'(g));

        // Close pulse: end flag while a start is open.
        always_comb close_o[g] = hit[g] && flags.last && open_q[g];

        // Track the open-start state of this queue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
            end else if (hit[g]) begin
                if (flags.last)       open_q[g] <= 1'b0;
                else if (flags.first) open_q[g] <= 1'b1;
            end
        end

        p_close_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            close_o[g] |=> !open_q[g]);
        p_both_is_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && flags.first && flags.last) |=> !open_q[g]);
        p_start_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && flags.first && !flags.last) |=> open_q[g]);
    end
endmodule

// File: rtl/pkt_q_counter.sv
// One per-queue complete-packet counter. Counts up on close pulses and down
// on read-side start flags. It saturates at both ends and holds when both
// arrive together. It exposes the post-edge ready value so the top can
// register status with one cycle of latency.
module pkt_q_counter #(
    parameter int MAX_CNT = 256,
    parameter int CNT_W   = $clog2(MAX_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ready_nxt
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_CNT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count with saturation and add/subtract cancellation.
    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != TOP)        cnt_d = cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    // Ready as it will be after this edge.
    always_comb ready_nxt = (cnt_d != '0);

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_hold_on_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && dec && !inc) |=> cnt_q == '0);
    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);
    p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/pkt_ready_tracker.sv
// Top: packet-ready status for a multi-queue FIFO. Latches packet operation
// at reset, filters write flags, decodes read start flags, keeps one counter
// per queue and registers an active-low bus and a read-selected flag.
// Assumes one clock, synchronous active-low reset, and that read gating
// happens elsewhere.
module pkt_ready_tracker
    import pkt_rdy_pkg::*;
#(
    parameter int NUM_Q  = 8,
    parameter int QDEPTH = 1024,
    parameter int QSEL_W = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_mode_sel,
    input  logic              wr_en,
    input  logic [QSEL_W-1:0] wr_q,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [QSEL_W-1:0] rd_q,
    input  logic [WORD_W-1:0] rd_word,
    output logic              pkt_rdy_n,
    output logic [NUM_Q-1:0]  pkt_rdy_bus_n
);
    localparam int MAX_PKTS = QDEPTH / MIN_PKT_WORDS;
    localparam int CNT_W    = $clog2(MAX_PKTS + 1);

    logic             mode_q;
    pkt_flags_t       wflags, rflags;
    logic [NUM_Q-1:0] close_v, drop_v, ready_v;
    logic [CNT_W-1:0] cnt_v [NUM_Q];
    logic             unused_bits;

    // Flag extraction from both ports; payload bits are not used here.
    always_comb wflags = take_flags(wr_word);
    always_comb rflags = take_flags(rd_word);
    always_comb unused_bits = ^{wr_word[START_BIT-1:0], rd_word[START_BIT-1:0],
                                rflags.last};

    // Latch packet operation while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= pkt_mode_sel;
    end

    pkt_wr_filter #(.NUM_Q(NUM_Q), .QSEL_W(QSEL_W)) i_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode_q),
        .wr_en   (wr_en),
        .wr_q    (wr_q),
        .flags   (wflags),
        .close_o (close_v)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        // Read-side start flag leaving this queue.
        always_comb drop_v[g] = mode_q && rd_en && rflags.first &&
                                (rd_q == QSEL_W'(g));

        pkt_q_counter #(.MAX_CNT(MAX_PKTS), .CNT_W(CNT_W)) i_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (close_v[g]),
            .dec       (drop_v[g]),
            .cnt_o     (cnt_v[g]),
            .ready_nxt (ready_v[g])
        );

        p_bus_matches_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (pkt_rdy_bus_n[g] == (cnt_v[g] == '0)));
    end

    // Register the status bus and the read-selected flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_rdy_bus_n <= '1;
            pkt_rdy_n     <= 1'b1;
        end else if (!mode_q) begin
            pkt_rdy_bus_n <= '1;
            pkt_rdy_n     <= 1'b1;
        end else begin
            pkt_rdy_bus_n <= ~ready_v;
            pkt_rdy_n     <= ~ready_v[rd_q];
        end
    end

    p_sel_follows_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pkt_rdy_n == pkt_rdy_bus_n[$past(rd_q)]));
    p_mode_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(mode_q));
    p_idle_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |=> (&pkt_rdy_bus_n && pkt_rdy_n));
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (&pkt_rdy_bus_n && pkt_rdy_n));
endmodule

// File: tb/test_pkt_ready_tracker.sv
module test_pkt_ready_tracker;
    localparam int NQ     = 8;
    localparam int QDEPTH = 16;
    localparam int MAXP   = QDEPTH / 4;

    logic        clk = 1'b0;
    logic        rst_n, pkt_mode_sel, wr_en, rd_en;
    logic [2:0]  wr_q, rd_q;
    logic [35:0] wr_word, rd_word;
    logic        pkt_rdy_n;
    logic [7:0]  pkt_rdy_bus_n;

    int n_cmp = 0;
    int n_bad = 0;
    int cnt_m [NQ];
    bit open_m [NQ];
    bit mode_m;

    always #10 clk = ~clk;

    pkt_ready_tracker #(.NUM_Q(NQ), .QDEPTH(QDEPTH)) i_pkt_ready_tracker (
        .clk(clk), .rst_n(rst_n), .pkt_mode_sel(pkt_mode_sel),
        .wr_en(wr_en), .wr_q(wr_q), .wr_word(wr_word),
        .rd_en(rd_en), .rd_q(rd_q), .rd_word(rd_word),
        .pkt_rdy_n(pkt_rdy_n), .pkt_rdy_bus_n(pkt_rdy_bus_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_bus();
        logic [7:0] b;
        for (int i = 0; i < NQ; i++) b[i] = !(mode_m && cnt_m[i] > 0);
        return b;
    endfunction

    // One cycle: drive at negedge, clock, update model, compare at negedge.
    task automatic step(input bit we, input int wq, input bit ws, input bit wl,
                        input bit re, input int rq, input bit rs);
        int inc_q, dec_q;
        wr_en   = we;
        wr_q    = 3'(wq);
        wr_word = {wl, ws, 34'($urandom)};
        rd_en   = re;
        rd_q    = 3'(rq);
        rd_word = {1'($urandom), rs, 34'($urandom)};
        @(posedge clk);
        inc_q = -1;
        dec_q = -1;
        if (mode_m && we) begin
            if (wl) begin
                if (open_m[wq]) inc_q = wq;
                open_m[wq] = 1'b0;
            end else if (ws) open_m[wq] = 1'b1;
        end
        if (mode_m && re && rs) dec_q = rq;
        for (int i = 0; i < NQ; i++) begin
            if ((inc_q == i) && (dec_q == i)) ;
            else if (inc_q == i && cnt_m[i] < MAXP) cnt_m[i]++;
            else if (dec_q == i && cnt_m[i] > 0)    cnt_m[i]--;
        end
        @(negedge clk);
        chk(pkt_rdy_bus_n == exp_bus(), "R9 bus", 32'(pkt_rdy_bus_n), 32'(exp_bus()));
        chk(pkt_rdy_n == exp_bus()[rq], "R10 sel", 32'(pkt_rdy_n), 32'(exp_bus()[rq]));
    endtask

    task automatic idle(input int rq);
        step(0, 0, 0, 0, 0, rq, 0);
    endtask

    task automatic do_reset(input bit m);
        rst_n = 1'b0;
        pkt_mode_sel = m;
        wr_en = 0; rd_en = 0; wr_q = 0; rd_q = 0; wr_word = '0; rd_word = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(pkt_rdy_bus_n == 8'hFF && pkt_rdy_n, "R1 reset outputs",
            32'({pkt_rdy_n, pkt_rdy_bus_n}), 32'h1FF);
        mode_m = m;
        for (int i = 0; i < NQ; i++) begin cnt_m[i] = 0; open_m[i] = 0; end
        rst_n = 1'b1;
    endtask

    task automatic send_pkt(input int q);
        step(1, q, 1, 0, 0, q, 0);
        step(1, q, 0, 0, 0, q, 0);
        step(1, q, 0, 0, 0, q, 0);
        step(1, q, 0, 1, 0, q, 0);
    endtask

    task automatic read_pkt(input int q);
        step(0, 0, 0, 0, 1, q, 1);
        step(0, 0, 0, 0, 1, q, 0);
        step(0, 0, 0, 0, 1, q, 0);
        step(0, 0, 0, 0, 1, q, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b1);
        idle(0);
        chk(pkt_rdy_bus_n == 8'hFF, "R1 after reset", 32'(pkt_rdy_bus_n), 32'hFF);

        // R2: dropping the select after reset keeps packet operation on.
        pkt_mode_sel = 1'b0;
        // R3 and R12: one packet per queue, each only sets its own bit.
        for (int q = 0; q < NQ; q++) begin
            send_pkt(q);
            chk(pkt_rdy_bus_n == ~8'((1 << (q + 1)) - 1), "R3 R12 R2 per queue",
                32'(pkt_rdy_bus_n), 32'(~8'((1 << (q + 1)) - 1)));
        end
        // R6: drain each queue; partial reads keep others intact.
        for (int q = 0; q < NQ; q++) begin
            read_pkt(q);
            chk(pkt_rdy_bus_n[q] == 1'b1, "R6 drained", 32'(pkt_rdy_bus_n[q]), 32'd1);
        end

        // R4: repeated start and repeated end collapse to one packet.
        step(1, 1, 1, 0, 0, 1, 0);
        step(1, 1, 1, 0, 0, 1, 0);
        step(1, 1, 0, 0, 0, 1, 0);
        step(1, 1, 0, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0, 1, 0);
        step(1, 1, 0, 1, 0, 1, 0);
        step(0, 0, 0, 0, 1, 1, 1);
        chk(pkt_rdy_bus_n[1] == 1'b1, "R4 orphan ends ignored",
            32'(pkt_rdy_bus_n[1]), 32'd1);

        // R5: a word with both flags closes the open packet.
        step(1, 3, 1, 0, 0, 3, 0);
        step(1, 3, 0, 0, 0, 3, 0);
        step(1, 3, 0, 0, 0, 3, 0);
        step(1, 3, 1, 1, 0, 3, 0);
        step(1, 3, 0, 1, 0, 3, 0);
        step(0, 0, 0, 0, 1, 3, 1);
        chk(pkt_rdy_bus_n[3] == 1'b1, "R5 both flags as end",
            32'(pkt_rdy_bus_n[3]), 32'd1);

        // R7: close and read-start on the same queue on one edge.
        send_pkt(4);
        step(1, 4, 1, 0, 0, 4, 0);
        step(1, 4, 0, 0, 0, 4, 0);
        step(1, 4, 0, 0, 0, 4, 0);
        step(1, 4, 0, 1, 1, 4, 1);
        chk(pkt_rdy_n == 1'b0, "R7 hold on both", 32'(pkt_rdy_n), 32'd0);
        step(0, 0, 0, 0, 1, 4, 1);
        chk(pkt_rdy_n == 1'b1, "R7 one left", 32'(pkt_rdy_n), 32'd1);

        // R8: six packets saturate at MAXP; reads floor at zero.
        for (int k = 0; k < MAXP + 2; k++) send_pkt(5);
        for (int k = 0; k < MAXP - 1; k++) step(0, 0, 0, 0, 1, 5, 1);
        chk(pkt_rdy_n == 1'b0, "R8 one before top", 32'(pkt_rdy_n), 32'd0);
        step(0, 0, 0, 0, 1, 5, 1);
        chk(pkt_rdy_n == 1'b1, "R8 saturated top", 32'(pkt_rdy_n), 32'd1);
        step(0, 0, 0, 0, 1, 5, 1);
        step(0, 0, 0, 0, 1, 5, 1);
        send_pkt(5);
        chk(pkt_rdy_n == 1'b0, "R8 floor at zero", 32'(pkt_rdy_n), 32'd0);

        // R10: sweep read selection over all queues.
        send_pkt(6);
        for (int q = 0; q < NQ; q++) idle(q);

        // Near-exhaustive random traffic against the count model.
        for (int k = 0; k < 4000; k++) begin
            int r = int'($urandom);
            step(r[0], r[3:1], r[4] & r[5], r[6] & r[7], r[8],
                 r[11:9], r[12] & r[13]);
        end

        // R11: packet operation off ignores all flags.
        do_reset(1'b0);
        send_pkt(2);
        send_pkt(2);
        chk(pkt_rdy_bus_n == 8'hFF && pkt_rdy_n, "R11 mode off",
            32'({pkt_rdy_n, pkt_rdy_bus_n}), 32'h1FF);
        for (int k = 0; k < 300; k++) begin
            int r = int'($urandom);
            step(r[0], r[3:1], r[4], r[5], r[6], r[9:7], r[10]);
        end

        do_reset(1'b1);
        send_pkt(7);
        chk(pkt_rdy_bus_n == 8'h7F, "R2 mode relatched", 32'(pkt_rdy_bus_n), 32'h7F);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule